// File: doc/BRIEF.md
# Speculative Thread Order Controller

This block sequences four processor cores that run the iterations of a loop as ordered speculative threads. When a speculative region opens, every core is handed one iteration. The controller keeps a rotating pointer to the core that holds the oldest thread. That thread is the only non-speculative one, and it is the only one allowed to commit. Cores report completion and read-too-early violations on plain per-core pins. The controller answers with one-cycle command pulses: start, restart, commit and squash.

A violation restarts the offending thread and every younger thread. The iteration each of them holds does not change. Completions are committed strictly in iteration order. A core that has just committed takes the next unissued iteration, so it becomes the youngest thread. The region-end strobe carries the last valid iteration number. Threads beyond that number are squashed, and no further iterations are issued. Each core's rank (0 is oldest) is published for the snoop and write-buffer logic that sits beside this block. All pins are plain level or pulse control signals, so the block has no back-pressure.

Top module: `spec_order_ctrl`

## Requirements
- R1: A begin strobe while no core is busy starts all cores in the same cycle. Core i gets iteration i and core 0 becomes the oldest. A begin strobe while any core is busy has no effect.
- R2: The rank output of core i is (i minus the oldest core's index) modulo 4, two bits per core, with core i at bits [2i+1:2i]. The oldest output is one-hot on the oldest core while that core is busy, and zero otherwise.
- R3: A violation from a busy core that is not the oldest pulses restart for that core and for every busy core of higher rank. The iterations of the restarted cores are unchanged. A violation from the oldest core or from an idle core is ignored.
- R4: When several cores report violations in the same cycle, the lowest-ranked valid reporter defines the restart set.
- R5: Only the oldest core commits, and at most one core commits per cycle. It commits when it signals done in that cycle or has a completion still pending. A completion from a younger core is held until that core becomes the oldest, and a restart of that core clears it.
- R6: A committing core is started again with the next unissued iteration, and the core after it becomes the oldest. Within a region, the iterations of busy cores rise by one per rank.
- R7: A region-end strobe with last iteration L, while cores are busy, squashes every busy core whose iteration exceeds L. After that no iteration beyond L is started. A second end strobe, or an end strobe with no core busy, is ignored.
- R8: Every command is a one-cycle pulse that appears on the clock edge after its cause. The region-active output falls once every thread has committed or been squashed.
- R9: A commit and a restart can occur in the same cycle, and both take effect. A squash overrides any restart or commit aimed at the same core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| region_begin_i | input | 1 | Strobe that opens a speculative region |
| region_end_i | input | 1 | Strobe that closes the region |
| region_last_i | input | IW | Last valid iteration, sampled with the end strobe |
| done_i | input | NCORE | Per-core thread completion |
| viol_i | input | NCORE | Per-core read-too-early violation |
| start_o | output | NCORE | Pulse: begin the thread shown on iter_o |
| restart_o | output | NCORE | Pulse: discard speculative state and re-run |
| commit_o | output | NCORE | Pulse: write buffer may drain to permanent state |
| squash_o | output | NCORE | Pulse: discard thread, core goes idle |
| busy_o | output | NCORE | Core holds a live thread |
| oldest_o | output | NCORE | One-hot marker of the non-speculative core |
| iter_o | output | NCORE*IW | Iteration held by each core |
| rank_o | output | NCORE*RW | Speculation rank per core, 0 is oldest |
| region_active_o | output | 1 | Some thread is still live |

## Verification
The collisions that matter are a commit of the oldest thread landing in the same cycle as a violation from a younger one, and a region end landing on top of either. The bench drives completion and violation bits independently on every core, with biased random draws, and ends regions at iterations close to the oldest one. Directed cycles force a completion of the oldest together with a violation two ranks younger. A reference model built from the requirements predicts every pulse, so a wrong commit, a missing restart or a lost pending completion shows up in that same cycle.

// File: rtl/spec_order_pkg.sv
package spec_order_pkg;

  // Per-core command bundle produced by the sequencer each cycle.
  typedef struct packed {
    logic launch;    // take a new iteration
    logic relaunch;  // re-execute current iteration
    logic retire;    // oldest thread commits
    logic kill;      // thread beyond region end
  } slot_cmd_t;

  // Forward distance around the core ring from one index to another.
  function automatic int unsigned ring_dist(input int unsigned from_idx,
                                            input int unsigned to_idx,
                                            input int unsigned n);
    return (to_idx + n - from_idx) % n;
  endfunction

endpackage

// File: rtl/spec_order_rank.sv
module spec_order_rank
  import spec_order_pkg::*;
#(
  parameter int unsigned NCORE = 4,
  parameter int unsigned RW    = 2
) (
  input  logic [RW-1:0]            head,
  input  logic [NCORE-1:0]         busy,
  input  logic [NCORE-1:0]         viol,
  output logic [NCORE-1:0][RW-1:0] rank,
  output logic [NCORE-1:0]         restart_mask
);

  logic          found;
  logic [RW-1:0] vmin;

  always_comb begin
    for (int i = 0; i < NCORE; i++) begin
      rank[i] = RW'(ring_dist(int'(head), i, NCORE));
    end
  end

  // Scan from youngest to second-oldest; the last hit is the oldest reporter.
  always_comb begin
    found = 1'b0;
    vmin  = '0;
    for (int r = NCORE - 1; r >= 1; r--) begin
      int c;
      c = (int'(head) + r) % NCORE;
      if (busy[c] && viol[c]) begin
        found = 1'b1;
        vmin  = RW'(r);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NCORE; i++) begin
      restart_mask[i] = found && busy[i] && (rank[i] >= vmin);
    end
  end

endmodule

// File: rtl/spec_order_slot.sv
module spec_order_slot
  import spec_order_pkg::*;
#(
  parameter int unsigned IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  slot_cmd_t     cmd,
  input  logic [IW-1:0] launch_iter,
  input  logic          done,
  output logic          busy,
  output logic [IW-1:0] iter,
  output logic          done_eff
);

  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      iter   <= '0;
      pend_q <= 1'b0;
    end else if (cmd.kill) begin
      busy   <= 1'b0;
      pend_q <= 1'b0;
    end else if (cmd.launch) begin
      busy   <= 1'b1;
      iter   <= launch_iter;
      pend_q <= 1'b0;
    end else if (cmd.retire) begin
      busy   <= 1'b0;
      pend_q <= 1'b0;
    end else if (cmd.relaunch) begin
      pend_q <= 1'b0;
    end else if (busy && done) begin
      pend_q <= 1'b1;
    end
  end

  assign done_eff = busy && (done || pend_q);

endmodule

// File: rtl/spec_order_ctrl.sv
module spec_order_ctrl
  import spec_order_pkg::*;
#(
  parameter  int unsigned NCORE = 4,
  parameter  int unsigned IW    = 16,
  localparam int unsigned RW    = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                region_begin_i,
  input  logic                region_end_i,
  input  logic [IW-1:0]       region_last_i,
  input  logic [NCORE-1:0]    done_i,
  input  logic [NCORE-1:0]    viol_i,
  output logic [NCORE-1:0]    start_o,
  output logic [NCORE-1:0]    restart_o,
  output logic [NCORE-1:0]    commit_o,
  output logic [NCORE-1:0]    squash_o,
  output logic [NCORE-1:0]    busy_o,
  output logic [NCORE-1:0]    oldest_o,
  output logic [NCORE*IW-1:0] iter_o,
  output logic [NCORE*RW-1:0] rank_o,
  output logic                region_active_o
);

  logic [RW-1:0]            head_q;
  logic [IW-1:0]            next_iter_q;
  logic [IW-1:0]            lim_q;
  logic                     lim_v_q;

  logic [NCORE-1:0]         busy_v;
  logic [NCORE-1:0]         done_eff;
  logic [NCORE-1:0][IW-1:0] iter_v;
  logic [NCORE-1:0][RW-1:0] rank_v;
  logic [NCORE-1:0]         restart_mask;

  logic [NCORE-1:0]         start_v;
  logic [NCORE-1:0]         restart_v;
  logic [NCORE-1:0]         commit_v;
  logic [NCORE-1:0]         squash_v;

  logic any_busy, begin_fire, end_fire, lim_v_c, can_start;
  logic [IW-1:0] lim_c;

  assign any_busy   = |busy_v;
  assign begin_fire = region_begin_i && !any_busy;
  assign end_fire   = region_end_i && any_busy && !lim_v_q;
  assign lim_c      = end_fire ? region_last_i : lim_q;
  assign lim_v_c    = end_fire || lim_v_q;
  assign can_start  = !lim_v_c || (next_iter_q <= lim_c);

  spec_order_rank #(.NCORE(NCORE), .RW(RW)) u_rank (
    .head         (head_q),
    .busy         (busy_v),
    .viol         (viol_i),
    .rank         (rank_v),
    .restart_mask (restart_mask)
  );

  for (genvar g = 0; g < NCORE; g++) begin : g_slot
    logic          is_head;
    logic [IW-1:0] launch_iter;
    slot_cmd_t     cmd;

    assign is_head      = (head_q == RW'(g));
    assign squash_v[g]  = end_fire && busy_v[g] && (iter_v[g] > region_last_i);
    assign commit_v[g]  = is_head && done_eff[g] && !squash_v[g];
    assign start_v[g]   = begin_fire || (commit_v[g] && can_start);
    assign restart_v[g] = restart_mask[g] && !squash_v[g];
    assign launch_iter  = begin_fire ? IW'(g) : next_iter_q;
    assign oldest_o[g]  = is_head && busy_v[g];

    assign cmd = '{launch:   start_v[g],
                   relaunch: restart_v[g],
                   retire:   commit_v[g],
                   kill:     squash_v[g]};

    spec_order_slot #(.IW(IW)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd         (cmd),
      .launch_iter (launch_iter),
      .done        (done_i[g]),
      .busy        (busy_v[g]),
      .iter        (iter_v[g]),
      .done_eff    (done_eff[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q      <= '0;
      next_iter_q <= '0;
      lim_q       <= '0;
      lim_v_q     <= 1'b0;
      start_o     <= '0;
      restart_o   <= '0;
      commit_o    <= '0;
      squash_o    <= '0;
    end else begin
      start_o   <= start_v;
      restart_o <= restart_v;
      commit_o  <= commit_v;
      squash_o  <= squash_v;
      if (begin_fire) begin
        head_q      <= '0;
        next_iter_q <= IW'(NCORE);
        lim_v_q     <= 1'b0;
      end else begin
        if (|commit_v) begin
          head_q <= (head_q == RW'(NCORE - 1)) ? '0 : head_q + 1'b1;
        end
        if (|start_v) begin
          next_iter_q <= next_iter_q + 1'b1;
        end
        if (end_fire) begin
          lim_q   <= region_last_i;
          lim_v_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o          = busy_v;
  assign iter_o          = iter_v;
  assign rank_o          = rank_v;
  assign region_active_o = any_busy;

endmodule

// File: rtl/spec_order_chk.sv
module spec_order_chk #(
  parameter int unsigned NCORE = 4,
  parameter int unsigned IW    = 16,
  parameter int unsigned RW    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NCORE-1:0]    start_o,
  input logic [NCORE-1:0]    restart_o,
  input logic [NCORE-1:0]    commit_o,
  input logic [NCORE-1:0]    squash_o,
  input logic [NCORE-1:0]    busy_o,
  input logic [NCORE-1:0]    oldest_o,
  input logic [NCORE*IW-1:0] iter_o,
  input logic [NCORE*RW-1:0] rank_o,
  input logic                region_active_o
);

  logic [NCORE*RW-1:0] p_rank;
  logic [NCORE-1:0]    p_busy;
  logic                tail_gap;
  logic                chain_bad;
  logic [NCORE-1:0]    rank_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_rank <= '0;
      p_busy <= '0;
    end else begin
      p_rank <= rank_o;
      p_busy <= busy_o;
    end
  end

  // A younger live thread skipped by a restart is a gap in the restart set.
  always_comb begin
    tail_gap = 1'b0;
    for (int i = 0; i < NCORE; i++) begin
      for (int j = 0; j < NCORE; j++) begin
        if (restart_o[i] && p_busy[j] && !restart_o[j] && !squash_o[j] &&
            (p_rank[j*RW +: RW] > p_rank[i*RW +: RW])) begin
          tail_gap = 1'b1;
        end
      end
    end
  end

  always_comb begin
    int h;
    h = 0;
    rank_seen = '0;
    for (int i = 0; i < NCORE; i++) begin
      rank_seen[int'(rank_o[i*RW +: RW]) % NCORE] = 1'b1;
      if (rank_o[i*RW +: RW] == '0) h = i;
    end
    chain_bad = 1'b0;
    for (int i = 0; i < NCORE; i++) begin
      if (busy_o[i] && (!busy_o[h] ||
          (iter_o[i*IW +: IW] != iter_o[h*IW +: IW] + IW'(rank_o[i*RW +: RW])))) begin
        chain_bad = 1'b1;
      end
    end
  end

  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(commit_o)); // R5
  AST_COMMIT_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    (|commit_o) |-> ((commit_o & $past(oldest_o)) == commit_o)); // R5
  AST_NO_OLDEST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_o & $past(oldest_o)) == '0); // R3
  AST_RESTART_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    !tail_gap); // R3
  AST_SQUASH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_o & (commit_o | restart_o | start_o)) == '0); // R9
  AST_START_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    ((start_o & ~commit_o) != '0) |-> $past(!region_active_o)); // R6
  AST_OLDEST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(oldest_o)); // R2
  AST_RANK_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    rank_seen == {NCORE{1'b1}}); // R2
  AST_ITER_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_bad); // R6

endmodule

bind spec_order_ctrl spec_order_chk #(.NCORE(NCORE), .IW(IW), .RW(RW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .start_o         (start_o),
  .restart_o       (restart_o),
  .commit_o        (commit_o),
  .squash_o        (squash_o),
  .busy_o          (busy_o),
  .oldest_o        (oldest_o),
  .iter_o          (iter_o),
  .rank_o          (rank_o),
  .region_active_o (region_active_o)
);

// File: tb/spec_order_ctrl_tb.sv
`timescale 1ns/1ps
module spec_order_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        region_begin_i = 1'b0;
  logic        region_end_i = 1'b0;
  logic [15:0] region_last_i = '0;
  logic [3:0]  done_i = '0;
  logic [3:0]  viol_i = '0;
  logic [3:0]  start_o, restart_o, commit_o, squash_o, busy_o, oldest_o;
  logic [63:0] iter_o;
  logic [7:0]  rank_o;
  logic        region_active_o;

  always #2.5 clk = ~clk;

  spec_order_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .region_begin_i(region_begin_i), .region_end_i(region_end_i),
    .region_last_i(region_last_i), .done_i(done_i), .viol_i(viol_i),
    .start_o(start_o), .restart_o(restart_o), .commit_o(commit_o),
    .squash_o(squash_o), .busy_o(busy_o), .oldest_o(oldest_o),
    .iter_o(iter_o), .rank_o(rank_o), .region_active_o(region_active_o)
  );

  int n_chk = 0;
  int n_err = 0;

  // Reference model state
  bit [3:0] m_busy, m_pend;
  int       m_iter [4];
  int       m_head, m_next, m_lim;
  bit       m_limv;
  bit [3:0] e_start, e_restart, e_commit, e_squash;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic model_reset();
    m_busy = '0; m_pend = '0; m_head = 0; m_next = 0; m_lim = 0; m_limv = 0;
    for (int i = 0; i < 4; i++) m_iter[i] = 0;
    e_start = '0; e_restart = '0; e_commit = '0; e_squash = '0;
  endtask

  task automatic model_step(input bit b, input bit e, input int last,
                            input bit [3:0] d, input bit [3:0] v);
    bit anyb, endf, limv, canst;
    int lim, vr, h;
    e_start = '0; e_restart = '0; e_commit = '0; e_squash = '0;
    anyb = |m_busy;
    if (b && !anyb) begin
      for (int i = 0; i < 4; i++) begin
        m_busy[i] = 1'b1; m_iter[i] = i; m_pend[i] = 1'b0;
      end
      e_start = 4'hF; m_head = 0; m_next = 4; m_limv = 1'b0;
      return;
    end
    endf = e && anyb && !m_limv;
    lim  = endf ? last : m_lim;
    limv = endf || m_limv;
    vr = 0;
    for (int r = 3; r >= 1; r--) begin
      int c;
      c = (m_head + r) % 4;
      if (m_busy[c] && v[c]) vr = r;
    end
    for (int c = 0; c < 4; c++) begin
      int rk;
      rk = (c - m_head + 4) % 4;
      e_squash[c]  = endf && m_busy[c] && (m_iter[c] > last);
      e_restart[c] = (vr != 0) && m_busy[c] && (rk >= vr) && !e_squash[c];
    end
    h = m_head;
    if (m_busy[h] && (d[h] || m_pend[h]) && !e_squash[h]) e_commit[h] = 1'b1;
    canst = !limv || (m_next <= lim);
    for (int c = 0; c < 4; c++) begin
      if (e_squash[c]) begin
        m_busy[c] = 1'b0; m_pend[c] = 1'b0;
      end else if (e_commit[c]) begin
        m_pend[c] = 1'b0;
        if (canst) begin
          m_iter[c] = m_next; e_start[c] = 1'b1;
        end else begin
          m_busy[c] = 1'b0;
        end
      end else if (e_restart[c]) begin
        m_pend[c] = 1'b0;
      end else if (m_busy[c] && d[c]) begin
        m_pend[c] = 1'b1;
      end
    end
    if (|e_commit) begin
      if (canst) m_next++;
      m_head = (h + 1) % 4;
    end
    m_lim = lim; m_limv = limv;
  endtask

  task automatic compare_all();
    chk("R6 start pulses", start_o, e_start);
    chk("R3 restart pulses", restart_o, e_restart);
    chk("R5 commit pulses", commit_o, e_commit);
    chk("R7 squash pulses", squash_o, e_squash);
    chk("R7 busy", busy_o, m_busy);
    chk("R2 oldest", oldest_o, m_busy[m_head] ? (1 << m_head) : 0);
    for (int i = 0; i < 4; i++) begin
      chk("R2 rank", rank_o[2*i +: 2], (i - m_head + 4) % 4);
      if (m_busy[i]) chk("R6 iteration", iter_o[16*i +: 16], m_iter[i]);
    end
    chk("R8 region active", region_active_o, |m_busy);
  endtask

  // Drive one cycle at a falling edge, predict, then compare at the next one.
  task automatic step(input bit b, input bit e, input int last,
                      input bit [3:0] d, input bit [3:0] v);
    region_begin_i = b; region_end_i = e; region_last_i = 16'(last);
    done_i = d; viol_i = v;
    model_step(b, e, last, d, v);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Reset state
    chk("R8 reset active", region_active_o, 0);
    chk("R8 reset pulses", start_o | restart_o | commit_o | squash_o, 0);
    chk("R2 reset rank", rank_o, 8'b11_10_01_00);
    compare_all();

    // R1: region opens, then a begin while busy does nothing
    step(1, 0, 0, 4'b0000, 4'b0000);
    chk("R1 all cores launched", start_o, 4'hF);
    chk("R1 core3 iteration", iter_o[48 +: 16], 3);
    step(1, 0, 0, 4'b0000, 4'b0000);
    chk("R1 begin while busy ignored", start_o, 0);
    // R5: younger completion held, oldest commits in order
    step(0, 0, 0, 4'b0100, 4'b0000);
    chk("R5 younger done no commit", commit_o, 0);
    step(0, 0, 0, 4'b0001, 4'b0000);
    chk("R5 oldest commits", commit_o, 4'b0001);
    chk("R6 relaunch iteration", iter_o[0 +: 16], 4);
    step(0, 0, 0, 4'b0010, 4'b0000);
    step(0, 0, 0, 4'b0000, 4'b0000);
    chk("R5 pending commit released", commit_o, 4'b0100);
    // R4: two reporters, the older one sets the restart set (head is core 3)
    step(0, 0, 0, 4'b0000, 4'b0101);
    chk("R4 oldest reporter wins", restart_o, 4'b0111);
    step(0, 0, 0, 4'b0000, 4'b1000);
    chk("R3 oldest violation ignored", restart_o, 0);
    // R9: commit and violation in one cycle
    step(0, 0, 0, 4'b1000, 4'b0010);
    chk("R9 commit with violation", commit_o, 4'b1000);
    chk("R9 restart with commit", restart_o, 4'b0110);
    // R7: end at iteration 5 with iterations 4..7 live
    step(0, 1, 5, 4'b0000, 4'b0000);
    chk("R7 squash beyond last", squash_o, 4'b1100);
    step(0, 0, 0, 4'b0011, 4'b0000);
    chk("R7 no start past last", start_o, 0);
    step(0, 0, 0, 4'b0000, 4'b0000);
    step(0, 0, 0, 4'b0000, 4'b0000);
    chk("R8 region closes", region_active_o, 0);

    // Constrained random phase
    for (int k = 0; k < 4000; k++) begin
      bit b, e;
      int last;
      bit [3:0] d, v;
      b = (|m_busy) ? ($urandom % 50 == 0) : ($urandom % 4 == 0);
      e = (|m_busy) ? ($urandom % 40 == 0) : ($urandom % 10 == 0);
      last = m_iter[m_head] + int'($urandom % 6) - 1;
      if (last < 0) last = 0;
      for (int i = 0; i < 4; i++) begin
        d[i] = ($urandom % 10) < 3;
        v[i] = ($urandom % 10) < 1;
      end
      step(b, e, last, d, v);
    end

    summary();
    $finish;
  end

endmodule